// File: doc/BRIEF.md
# Two-Port Address Contention Arbiter

This block sits between the two independent request ports of a shared two-port memory and the array itself. On every cycle it compares the addresses of the two ports. When both ports are enabled and point at the same word, it grants the word to the port that was already there. It signals the other port with an active-low busy line and withholds that port's write from the array until the conflict is over. When the ports do not collide, both busy lines stay released, and each port's write strobe passes straight through to the array as a qualified write enable.

The block is a small synchronous state machine. It has three states:
- `ARB_IDLE`: no contention.
- `ARB_LEFT_OWNS`: the left port holds the contested word.
- `ARB_RIGHT_OWNS`: the right port holds the contested word.

It has four transitions:
- *claim-left*: from `ARB_IDLE` to `ARB_LEFT_OWNS`.
- *claim-right*: from `ARB_IDLE` to `ARB_RIGHT_OWNS`.
- *hold*: an owner state back to itself while contention lasts.
- *release*: an owner state back to `ARB_IDLE` when contention ends.

A port "moved" in a cycle when its enable or address differs from the value captured at the previous clock edge. The port that did not move is the one that settled first, and it wins. When both ports moved, or neither did, the left port wins. Busy and write-enable outputs are combinational from the present inputs and the registered state, so a conflict blocks a write in the very cycle it appears.

Top module: `contention_arbiter`

## Requirements
- R1: When either enable is high (inactive) or the two addresses differ, both busy outputs are high.
- R2: When contention appears (both enables low and equal addresses) and only one port moved, the moved port gets busy low and the other keeps access. Moved means its enable or address differs from its value at the previous clock edge.
- R3: When contention appears and both ports moved, or neither moved, the left port wins and right busy goes low.
- R4: The two busy outputs are never low together, and during contention exactly one of them is low.
- R5: A port's write enable to the array is high exactly when its enable is low, its write strobe is low and its busy is high. A busy port's write therefore never reaches the array.
- R6: Contention is detected both when an address changes to match the other port and when an enable falls while the addresses already match.
- R7: The winner is kept for as long as contention lasts, even when both ports move to a new common address. Both busy outputs return high in the same cycle the contention ends.
- R8: The write strobes take no part in arbitration. Two reads of the same word still raise busy on the losing side.
- R9: Reset returns the machine to `ARB_IDLE` and sets each port's captured enable to inactive. The first contention after reset is therefore resolved as a simultaneous arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_ce_n | input | 1 | Left port enable, active low |
| left_addr | input | AW | Left port word address |
| left_we_n | input | 1 | Left port write strobe, active low |
| right_ce_n | input | 1 | Right port enable, active low |
| right_addr | input | AW | Right port word address |
| right_we_n | input | 1 | Right port write strobe, active low |
| left_busy_n | output | 1 | Busy to left port, active low |
| right_busy_n | output | 1 | Busy to right port, active low |
| left_wr_en | output | 1 | Qualified left write enable to the array |
| right_wr_en | output | 1 | Qualified right write enable to the array |

## Verification
The checker enforces several properties on every cycle:
- Both busy lines are free without contention.
- Exactly one busy line is low during contention.
- A busy port never produces a write enable.
- An established winner is never displaced while contention lasts.
- A port that moved alone into contention loses.

Which port wins a tie, and how arbitration behaves after a reset taken in mid-contention, are shown only by the bench's scenarios. The same holds for the exact write-enable values across every combination of enables, strobes and addresses, and for a joint move of both ports to a new common address while an owner holds.

// File: rtl/ca_pkg.sv
package ca_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_LEFT_OWNS  = 2'd1,
        ARB_RIGHT_OWNS = 2'd2
    } arb_state_e;

    localparam int NUM_PORTS = 2;
    localparam int PORT_LEFT  = 0;
    localparam int PORT_RIGHT = 1;
endpackage

// File: rtl/ca_match_detect.sv
module ca_match_detect #(
    parameter int AW = 11
) (
    input  logic          l_ce_n,
    input  logic [AW-1:0] l_addr,
    input  logic          r_ce_n,
    input  logic [AW-1:0] r_addr,
    output logic          contend
);
    // Both ports selected and pointing at the same word.
    always_comb begin
        contend = !l_ce_n && !r_ce_n && (l_addr == r_addr);
    end
endmodule

// File: rtl/ca_arrival_track.sv
module ca_arrival_track #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic [AW-1:0] addr,
    output logic          moved
);
    logic          prev_ce_n;
    logic [AW-1:0] prev_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ce_n <= 1'b1;
            prev_addr <= '0;
        end else begin
            prev_ce_n <= ce_n;
            prev_addr <= addr;
        end
    end

    // A port that changed since the last edge has not settled yet.
    always_comb begin
        moved = (ce_n != prev_ce_n) || (addr != prev_addr);
    end
endmodule

// File: rtl/ca_winner_fsm.sv
module ca_winner_fsm
    import ca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic contend,
    input  logic l_moved,
    input  logic r_moved,
    output logic l_busy_n,
    output logic r_busy_n
);
    arb_state_e state_q;
    arb_state_e state_d;

    // Next-state logic: claim-left, claim-right, hold, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (contend) begin
                    if (l_moved && !r_moved) state_d = ARB_RIGHT_OWNS;
                    else                     state_d = ARB_LEFT_OWNS;
                end
            end
            ARB_LEFT_OWNS: begin
                if (!contend) state_d = ARB_IDLE;
            end
            ARB_RIGHT_OWNS: begin
                if (!contend) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Outputs: the loser of the current or just-claimed contention is busy.
    always_comb begin
        l_busy_n = 1'b1;
        r_busy_n = 1'b1;
        unique case (state_d)
            ARB_IDLE:       ;
            ARB_LEFT_OWNS:  r_busy_n = 1'b0;
            ARB_RIGHT_OWNS: l_busy_n = 1'b0;
            default:        ;
        endcase
    end
endmodule

// File: rtl/contention_arbiter.sv
module contention_arbiter
    import ca_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          left_ce_n,
    input  logic [AW-1:0] left_addr,
    input  logic          left_we_n,
    input  logic          right_ce_n,
    input  logic [AW-1:0] right_addr,
    input  logic          right_we_n,
    output logic          left_busy_n,
    output logic          right_busy_n,
    output logic          left_wr_en,
    output logic          right_wr_en
);
    logic                 contend;
    logic [NUM_PORTS-1:0] port_ce_n;
    logic [AW-1:0]        port_addr [NUM_PORTS];
    logic [NUM_PORTS-1:0] port_moved;

    assign port_ce_n[PORT_LEFT]  = left_ce_n;
    assign port_ce_n[PORT_RIGHT] = right_ce_n;
    assign port_addr[PORT_LEFT]  = left_addr;
    assign port_addr[PORT_RIGHT] = right_addr;

    ca_match_detect #(.AW(AW)) u_match (
        .l_ce_n  (left_ce_n),
        .l_addr  (left_addr),
        .r_ce_n  (right_ce_n),
        .r_addr  (right_addr),
        .contend (contend)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_track
        ca_arrival_track #(.AW(AW)) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .ce_n  (port_ce_n[p]),
            .addr  (port_addr[p]),
            .moved (port_moved[p])
        );
    end

    ca_winner_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .contend  (contend),
        .l_moved  (port_moved[PORT_LEFT]),
        .r_moved  (port_moved[PORT_RIGHT]),
        .l_busy_n (left_busy_n),
        .r_busy_n (right_busy_n)
    );

    // Write gating: a busy port never reaches the array.
    assign left_wr_en  = !left_ce_n  && !left_we_n  && left_busy_n;
    assign right_wr_en = !right_ce_n && !right_we_n && right_busy_n;
endmodule

// File: rtl/contention_arbiter_chk.sv
module contention_arbiter_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          left_ce_n,
    input logic [AW-1:0] left_addr,
    input logic          left_we_n,
    input logic          right_ce_n,
    input logic [AW-1:0] right_addr,
    input logic          right_we_n,
    input logic          left_busy_n,
    input logic          right_busy_n,
    input logic          left_wr_en,
    input logic          right_wr_en
);
    logic clash;
    logic armed;

    assign clash = !left_ce_n && !right_ce_n && (left_addr == right_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1
    free_when_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clash |-> (left_busy_n && right_busy_n));

    // R4
    single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> ($countones({~left_busy_n, ~right_busy_n}) == 1));

    // R4
    never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_busy_n || right_busy_n));

    // R5
    left_blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !left_busy_n |-> !left_wr_en);

    // R5
    right_blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !right_busy_n |-> !right_wr_en);

    // R7
    left_owner_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && !right_busy_n) |=> (!clash || !right_busy_n));

    // R7
    right_owner_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && !left_busy_n) |=> (!clash || !left_busy_n));

    // R2
    late_left_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && clash && !$past(clash) && $stable(right_ce_n) && $stable(right_addr)
         && !($stable(left_ce_n) && $stable(left_addr))) |-> !left_busy_n);

    // R2
    late_right_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && clash && !$past(clash) && $stable(left_ce_n) && $stable(left_addr)
         && !($stable(right_ce_n) && $stable(right_addr))) |-> !right_busy_n);
endmodule

bind contention_arbiter contention_arbiter_chk #(.AW(AW)) u_chk (.*);

// File: tb/contention_arbiter_tb.sv
module contention_arbiter_tb;
    localparam int AW = 3;
    localparam int NA = 1 << AW;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_ce_n = 1'b1, r_ce_n = 1'b1, l_we_n = 1'b1, r_we_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_n, r_busy_n, l_wr_en, r_wr_en;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    contention_arbiter #(.AW(AW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .left_ce_n    (l_ce_n),
        .left_addr    (l_addr),
        .left_we_n    (l_we_n),
        .right_ce_n   (r_ce_n),
        .right_addr   (r_addr),
        .right_we_n   (r_we_n),
        .left_busy_n  (l_busy_n),
        .right_busy_n (r_busy_n),
        .left_wr_en   (l_wr_en),
        .right_wr_en  (r_wr_en)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES && !done) begin
            n_fail++;
            $display("FAIL watchdog: run hung after %0d cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic drive(input logic lce, input logic [AW-1:0] la, input logic lwe,
                         input logic rce, input logic [AW-1:0] ra, input logic rwe);
        @(negedge clk);
        l_ce_n = lce; l_addr = la; l_we_n = lwe;
        r_ce_n = rce; r_addr = ra; r_we_n = rwe;
        #1;
    endtask

    task automatic expect4(input string req, input logic elb, input logic erb,
                           input logic elw, input logic erw);
        n_checks++;
        if ({l_busy_n, r_busy_n, l_wr_en, r_wr_en} !== {elb, erb, elw, erw}) begin
            n_fail++;
            $display("FAIL %s: got lb=%b rb=%b lw=%b rw=%b expected lb=%b rb=%b lw=%b rw=%b",
                     req, l_busy_n, r_busy_n, l_wr_en, r_wr_en, elb, erb, elw, erw);
        end
    endtask

    task automatic go_idle();
        drive(1, '0, 1, 1, '0, 1);
        expect4("R1 idle", 1, 1, 0, 0);
    endtask

    initial begin
        // R9 reset state
        #1;
        expect4("R9 in reset", 1, 1, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect4("R9 after reset", 1, 1, 0, 0);

        // R1 R3 R5 R8: exhaustive sweep of simultaneous arrival from idle
        for (int la = 0; la < NA; la++)
            for (int ra = 0; ra < NA; ra++)
                for (int k = 0; k < 16; k++) begin
                    logic lce, rce, lwe, rwe, c;
                    {lce, rce, lwe, rwe} = k[3:0];
                    go_idle();
                    drive(lce, AW'(la), lwe, rce, AW'(ra), rwe);
                    c = !lce && !rce && (la == ra);
                    if (!c)
                        expect4("R1 R5 no contention", 1, 1, !lce && !lwe, !rce && !rwe);
                    else if (lwe && rwe)
                        expect4("R8 R3 read tie", 1, 0, 0, 0);
                    else
                        expect4("R3 R5 tie left wins", 1, 0, !lwe, 1'b0);
                end

        // R2 R5 R7: right settles first, then left arrives
        for (int a = 0; a < NA; a++) begin
            logic [AW-1:0] aa, bb;
            aa = AW'(a);
            bb = AW'(a + 5);
            go_idle();
            drive(1, '0, 1, 0, aa, 1);
            expect4("R1 right alone", 1, 1, 0, 0);
            drive(0, aa, 0, 0, aa, 1);
            expect4("R2 R6 late left busy", 0, 1, 0, 0);
            drive(0, aa, 0, 0, aa, 0);
            expect4("R7 R5 right owner writes", 0, 1, 0, 1);
            drive(0, bb, 0, 0, bb, 1);
            expect4("R7 owner kept on joint move", 0, 1, 0, 0);
            drive(0, bb, 0, 0, AW'(bb + 1), 1);
            expect4("R7 release on mismatch", 1, 1, 1, 0);
        end

        // R2 R5 R7: left settles first, then right arrives
        for (int a = 0; a < NA; a++) begin
            logic [AW-1:0] aa;
            aa = AW'(a);
            go_idle();
            drive(0, aa, 1, 1, '0, 1);
            expect4("R1 left alone", 1, 1, 0, 0);
            drive(0, aa, 1, 0, aa, 0);
            expect4("R2 R6 late right busy write blocked", 1, 0, 0, 0);
            drive(0, aa, 0, 0, aa, 0);
            expect4("R7 R5 left owner writes", 1, 0, 1, 0);
            drive(0, aa, 0, 1, aa, 0);
            expect4("R7 R1 release on enable high", 1, 1, 1, 0);
        end

        // R6: contention reached by an address change
        for (int a = 0; a < NA; a++) begin
            logic [AW-1:0] aa;
            aa = AW'(a);
            go_idle();
            drive(0, aa, 1, 0, AW'(a + 3), 0);
            expect4("R1 enabled apart", 1, 1, 0, 1);
            drive(0, aa, 1, 0, aa, 0);
            expect4("R6 right moves onto left", 1, 0, 0, 0);
            go_idle();
            drive(0, AW'(a + 2), 0, 0, aa, 1);
            expect4("R1 enabled apart", 1, 1, 1, 0);
            drive(0, aa, 0, 0, aa, 1);
            expect4("R6 left moves onto right", 0, 1, 0, 0);
        end

        // R9: reset in mid-contention, first contention after reset is a tie
        go_idle();
        drive(1, '0, 1, 0, 3'd4, 1);
        drive(0, 3'd4, 1, 0, 3'd4, 1);
        expect4("R2 right owns before reset", 0, 1, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect4("R9 tie after reset", 1, 0, 0, 0);
        @(negedge clk);
        #1;
        expect4("R9 R7 left kept after reset", 1, 0, 0, 0);
        go_idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule